// File: doc/BRIEF.md
# Card Interface Command Strobe Timer

This block times one access on a PC Card style slot, counting in memory clocks. A requester raises `req` with a socket number, an address space (common memory, attribute or I/O) and a direction. The block first holds the address stable with both strobes high for a setup interval. It then drives the read or the write strobe low. While the strobe is low it waits a minimum time and then watches the card's active-low wait line. After that line is seen released it keeps the strobe low for a further interval, whose length depends on the direction. It then releases the strobe, holds the address for a hold interval, and pulses `ack`.

Each combination of socket and space has its own three timing fields: a 7-bit setup field, a 6-bit hold field and a 5-bit command code. They arrive as flat configuration buses that a register block elsewhere drives. Slot `s*3 + p` of each bus holds the field for socket `s` and space `p`, where field width W sits at bits `[slot*W +: W]`. The request selects are captured when the request is accepted and then used for the whole access.

Top module: `cmd_strobe_timer`

## Requirements
- R1: After reset, and whenever no access is in progress, `rd_strobe_n` and `wr_strobe_n` are both 1 and `ack` is 0.
- R2: Once a request is accepted, both strobes stay high for exactly setup field + 2 clocks before a strobe goes low.
- R3: After the strobe goes low, the wait input is first sampled at the end of strobe-low clock code + 2. If `card_wait_n` is 0 there, or at any later sample, the strobe stays low and the block samples again on the next clock.
- R4: For a write (`req_write` = 1), `wr_strobe_n` stays low for 2*code + 3 clocks after the clock in which `card_wait_n` is sampled 1. With no stall the total is 3*code + 5 clocks.
- R5: For a read (`req_write` = 0), `rd_strobe_n` stays low for 2*code + 4 clocks after the release sample. With no stall the total is 3*code + 6 clocks.
- R6: After the strobe rises, both strobes stay high for exactly hold field + 2 clocks. `ack` is 1 in the last of those clocks only, and is 0 in the clock after it.
- R7: `rd_strobe_n` and `wr_strobe_n` are never 0 together. Only the strobe that matches the captured direction is ever driven low.
- R8: Changes on `req`, `req_sock`, `req_space` and `req_write` during an access have no effect on its strobe choice or its timing.
- R9: Timing is taken from the field slot `req_sock*3 + req_space`, with space code 0 for common memory, 1 for attribute and 2 for I/O.
- R10: A request with space code 3 is not accepted: no strobe goes low and no `ack` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_setup | input | NSOCK*3*SET_W | Setup fields, one per socket and space slot |
| cfg_hold | input | NSOCK*3*HOLD_W | Hold fields, one per slot |
| cfg_code | input | NSOCK*3*CODE_W | Command assertion codes, one per slot |
| req | input | 1 | Access request, taken while idle |
| req_sock | input | SOCK_W | Socket select |
| req_space | input | 2 | Space select: 0 common, 1 attribute, 2 I/O |
| req_write | input | 1 | 1 = write strobe, 0 = read strobe |
| card_wait_n | input | 1 | Card wait, low means stall |
| ack | output | 1 | One-clock completion pulse |
| rd_strobe_n | output | 1 | Active-low read command strobe |
| wr_strobe_n | output | 1 | Active-low write command strobe |

## Verification
The end of the minimum wait interval and the release of the card's wait line can fall on the same clock. That is the edge case this block must get right. The bench releases wait exactly on strobe-low clock code + 2, one clock before it, and well after it. It judges each case by counting the strobe-low clocks against the code-based total plus any stall beyond the minimum. A second case is the completion clock meeting a request that is still held high, with its selects flipped. There the strobe choice, the intervals and a single-clock `ack` are checked.

// File: rtl/cst_pkg.sv
package cst_pkg;

  localparam int SPACE_N = 3;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_SETUP    = 3'd1,
    PH_CMD_MIN  = 3'd2,
    PH_CMD_POLL = 3'd3,
    PH_CMD_POST = 3'd4,
    PH_HOLD     = 3'd5
  } phase_e;

  // address setup interval in clocks
  function automatic int setup_cycles(input int field);
    return field + 2;
  endfunction

  // address hold interval in clocks
  function automatic int hold_cycles(input int field);
    return field + 2;
  endfunction

  // strobe-low clocks before the first wait sample
  function automatic int wait_cycles(input int code);
    return code + 2;
  endfunction

  // strobe-low clocks after the release sample
  function automatic int post_cycles(input int code, input logic is_write);
    return 2 * code + (is_write ? 3 : 4);
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // counter width able to hold every interval minus one
  function automatic int count_width(input int set_w, input int hold_w, input int code_w);
    int longest;
    longest = max_of(setup_cycles((1 << set_w) - 1), hold_cycles((1 << hold_w) - 1));
    longest = max_of(longest, post_cycles((1 << code_w) - 1, 1'b0));
    longest = max_of(longest, wait_cycles((1 << code_w) - 1));
    return max_of($clog2(longest), 1);
  endfunction

endpackage

// File: rtl/cst_cfg_select.sv
module cst_cfg_select
  import cst_pkg::*;
#(
  parameter int NSOCK  = 2,
  parameter int SET_W  = 7,
  parameter int HOLD_W = 6,
  parameter int CODE_W = 5,
  parameter int SOCK_W = 1
) (
  input  logic [NSOCK*SPACE_N*SET_W-1:0]  setup_bus,
  input  logic [NSOCK*SPACE_N*HOLD_W-1:0] hold_bus,
  input  logic [NSOCK*SPACE_N*CODE_W-1:0] code_bus,
  input  logic [SOCK_W-1:0]               sel_sock,
  input  logic [1:0]                      sel_space,
  output logic [SET_W-1:0]                setup_f,
  output logic [HOLD_W-1:0]               hold_f,
  output logic [CODE_W-1:0]               code_f
);

  localparam int SLOTS = NSOCK * SPACE_N;

  logic [SET_W-1:0]  setup_a [SLOTS];
  logic [HOLD_W-1:0] hold_a  [SLOTS];
  logic [CODE_W-1:0] code_a  [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign setup_a[g] = setup_bus[g*SET_W +: SET_W];
    assign hold_a[g]  = hold_bus[g*HOLD_W +: HOLD_W];
    assign code_a[g]  = code_bus[g*CODE_W +: CODE_W];
  end

  int slot;

  always_comb begin
    slot    = int'(sel_sock) * SPACE_N + int'(sel_space);
    setup_f = '0;
    hold_f  = '0;
    code_f  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (slot == i) begin
        setup_f = setup_a[i];
        hold_f  = hold_a[i];
        code_f  = code_a[i];
      end
    end
  end

endmodule

// File: rtl/cst_phase_counter.sv
module cst_phase_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             zero
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (load)           count <= load_val;
    else if (count != '0)    count <= count - 1'b1;
  end

  assign zero = (count == '0);

  // R2: each interval is counted down one clock at a time
  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> (count == $past(count) - 1'b1));

  // a loaded value is held exactly
  p_load_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));

endmodule

// File: rtl/cst_seq_fsm.sv
module cst_seq_fsm
  import cst_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_ok,
  input  logic             card_wait_n,
  input  logic             cnt_zero,
  input  logic             cap_write,
  input  logic [CNT_W-1:0] setup_ld,
  input  logic [CNT_W-1:0] wait_ld,
  input  logic [CNT_W-1:0] post_ld,
  input  logic [CNT_W-1:0] hold_ld,
  output phase_e           phase,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             accept,
  output logic             ack,
  output logic             rd_strobe_n,
  output logic             wr_strobe_n
);

  phase_e nxt;
  logic   cmd_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end

  always_comb begin
    nxt      = phase;
    cnt_load = 1'b0;
    cnt_val  = '0;
    accept   = 1'b0;
    ack      = 1'b0;
    unique case (phase)
      PH_IDLE: if (req_ok) begin
        nxt = PH_SETUP; cnt_load = 1'b1; cnt_val = setup_ld; accept = 1'b1;
      end
      PH_SETUP: if (cnt_zero) begin
        nxt = PH_CMD_MIN; cnt_load = 1'b1; cnt_val = wait_ld;
      end
      PH_CMD_MIN: if (cnt_zero) begin
        if (card_wait_n) begin
          nxt = PH_CMD_POST; cnt_load = 1'b1; cnt_val = post_ld;
        end else begin
          nxt = PH_CMD_POLL;
        end
      end
      PH_CMD_POLL: if (card_wait_n) begin
        nxt = PH_CMD_POST; cnt_load = 1'b1; cnt_val = post_ld;
      end
      PH_CMD_POST: if (cnt_zero) begin
        nxt = PH_HOLD; cnt_load = 1'b1; cnt_val = hold_ld;
      end
      PH_HOLD: if (cnt_zero) begin
        nxt = PH_IDLE; ack = 1'b1;
      end
      default: nxt = PH_IDLE;
    endcase
  end

  assign cmd_active  = (phase == PH_CMD_MIN) || (phase == PH_CMD_POLL) ||
                       (phase == PH_CMD_POST);
  assign rd_strobe_n = !(cmd_active && !cap_write);
  assign wr_strobe_n = !(cmd_active && cap_write);

  // R3: minimum wait runs to its end before any sampling
  p_min_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CMD_MIN && !cnt_zero) |=> (phase == PH_CMD_MIN));

  // R3: a stalled card keeps the strobe asserted
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_CMD_POLL || (phase == PH_CMD_MIN && cnt_zero)) && !card_wait_n)
      |=> (phase == PH_CMD_POLL));

  // R6: completion pulse lasts one clock
  p_ack_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R7: strobes never low together
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_strobe_n && !wr_strobe_n));

  // R7: write strobe only for a write access
  p_strobe_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe_n |-> cap_write);

endmodule

// File: rtl/cmd_strobe_timer.sv
module cmd_strobe_timer
  import cst_pkg::*;
#(
  parameter int NSOCK  = 2,
  parameter int SET_W  = 7,
  parameter int HOLD_W = 6,
  parameter int CODE_W = 5,
  localparam int SOCK_W = (NSOCK > 1) ? $clog2(NSOCK) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NSOCK*SPACE_N*SET_W-1:0]  cfg_setup,
  input  logic [NSOCK*SPACE_N*HOLD_W-1:0] cfg_hold,
  input  logic [NSOCK*SPACE_N*CODE_W-1:0] cfg_code,
  input  logic                            req,
  input  logic [SOCK_W-1:0]               req_sock,
  input  logic [1:0]                      req_space,
  input  logic                            req_write,
  input  logic                            card_wait_n,
  output logic                            ack,
  output logic                            rd_strobe_n,
  output logic                            wr_strobe_n
);

  localparam int CNT_W = count_width(SET_W, HOLD_W, CODE_W);

  phase_e             phase;
  logic               in_idle;
  logic               req_ok;
  logic               accept;
  logic               cnt_load;
  logic               cnt_zero;
  logic [CNT_W-1:0]   cnt_val;
  logic [CNT_W-1:0]   count;
  logic [SOCK_W-1:0]  cap_sock;
  logic [1:0]         cap_space;
  logic               cap_write;
  logic [SOCK_W-1:0]  sel_sock;
  logic [1:0]         sel_space;
  logic [SET_W-1:0]   setup_f;
  logic [HOLD_W-1:0]  hold_f;
  logic [CODE_W-1:0]  code_f;
  logic [CNT_W-1:0]   setup_ld;
  logic [CNT_W-1:0]   wait_ld;
  logic [CNT_W-1:0]   post_ld;
  logic [CNT_W-1:0]   hold_ld;

  assign in_idle = (phase == PH_IDLE);
  assign req_ok  = req && (int'(req_space) < SPACE_N) && (int'(req_sock) < NSOCK);

  // request selects are held for the whole access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_sock  <= '0;
      cap_space <= '0;
      cap_write <= 1'b0;
    end else if (accept) begin
      cap_sock  <= req_sock;
      cap_space <= req_space;
      cap_write <= req_write;
    end
  end

  // while idle the setup length comes straight from the request
  assign sel_sock  = in_idle ? req_sock  : cap_sock;
  assign sel_space = in_idle ? req_space : cap_space;

  cst_cfg_select #(
    .NSOCK(NSOCK), .SET_W(SET_W), .HOLD_W(HOLD_W), .CODE_W(CODE_W), .SOCK_W(SOCK_W)
  ) cfg_sel_i (
    .setup_bus(cfg_setup), .hold_bus(cfg_hold), .code_bus(cfg_code),
    .sel_sock(sel_sock), .sel_space(sel_space),
    .setup_f(setup_f), .hold_f(hold_f), .code_f(code_f)
  );

  assign setup_ld = CNT_W'(setup_cycles(int'(setup_f)) - 1);
  assign hold_ld  = CNT_W'(hold_cycles(int'(hold_f)) - 1);
  assign wait_ld  = CNT_W'(wait_cycles(int'(code_f)) - 1);
  assign post_ld  = CNT_W'(post_cycles(int'(code_f), cap_write) - 1);

  cst_phase_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .count(count), .zero(cnt_zero)
  );

  cst_seq_fsm #(.CNT_W(CNT_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .req_ok(req_ok), .card_wait_n(card_wait_n),
    .cnt_zero(cnt_zero), .cap_write(cap_write),
    .setup_ld(setup_ld), .wait_ld(wait_ld), .post_ld(post_ld), .hold_ld(hold_ld),
    .phase(phase), .cnt_load(cnt_load), .cnt_val(cnt_val), .accept(accept),
    .ack(ack), .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n)
  );

  // R8: captured selects do not move during an access
  p_sel_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_idle |=> (in_idle || ($stable(cap_sock) && $stable(cap_space) && $stable(cap_write))));

  // R10: an unknown space code leaves the block idle
  p_reject_space_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && int'(req_space) >= SPACE_N) |=> in_idle);

  // R1: idle block drives no strobe and no ack
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> (rd_strobe_n && wr_strobe_n && !ack));

endmodule

// File: tb/cmd_strobe_timer_tb_top.sv
module cmd_strobe_timer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 6;

  typedef struct packed {
    logic       sock;
    logic [1:0] space;
    logic       wr;
    logic [6:0] setup;
    logic [5:0] hold;
    logic [4:0] code;
    logic [7:0] rel;
  } vec_t;

  // rel: strobe-low clock index on which wait is first seen released (0 = at once)
  localparam vec_t VECS [8] = '{
    '{1'b0, 2'd0, 1'b1, 7'd0,   6'd0,  5'd0,  8'd0},
    '{1'b0, 2'd0, 1'b0, 7'd0,   6'd0,  5'd0,  8'd0},
    '{1'b1, 2'd1, 1'b1, 7'd3,   6'd1,  5'd2,  8'd0},
    '{1'b1, 2'd2, 1'b0, 7'd0,   6'd4,  5'd4,  8'd0},
    '{1'b0, 2'd2, 1'b1, 7'd2,   6'd2,  5'd1,  8'd3},
    '{1'b0, 2'd1, 1'b0, 7'd1,   6'd3,  5'd1,  8'd10},
    '{1'b1, 2'd0, 1'b1, 7'd127, 6'd63, 5'd31, 8'd0},
    '{1'b1, 2'd1, 1'b0, 7'd5,   6'd0,  5'd3,  8'd4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSLOT*7-1:0] cfg_setup = '0;
  logic [NSLOT*6-1:0] cfg_hold = '0;
  logic [NSLOT*5-1:0] cfg_code = '0;
  logic       req = 1'b0;
  logic       req_sock = 1'b0;
  logic [1:0] req_space = 2'd0;
  logic       req_write = 1'b0;
  logic       card_wait_n = 1'b1;
  logic       ack;
  logic       rd_strobe_n;
  logic       wr_strobe_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_strobe_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
    .cfg_code(cfg_code), .req(req), .req_sock(req_sock), .req_space(req_space),
    .req_write(req_write), .card_wait_n(card_wait_n), .ack(ack),
    .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check_int(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  // fill every slot with decoy values, then the target slot with the wanted ones
  task automatic load_cfg(input int tgt, input int s, input int h, input int c);
    for (int i = 0; i < NSLOT; i++) begin
      cfg_setup[i*7 +: 7] = 7'((s + 5 + i) % 128);
      cfg_hold[i*6 +: 6]  = 6'((h + 7 + i) % 64);
      cfg_code[i*5 +: 5]  = 5'((c + 3 + i) % 32);
    end
    cfg_setup[tgt*7 +: 7] = 7'(s);
    cfg_hold[tgt*6 +: 6]  = 6'(h);
    cfg_code[tgt*5 +: 5]  = 5'(c);
  endtask

  task automatic do_access(input logic sk, input logic [1:0] sp, input logic wr,
                           input int rel, input bit wiggle,
                           output int n_set, output int n_cmd, output int n_hold,
                           output int bad_strobe, output int ack_after);
    int phase_b = 0;
    int guard = 0;
    bit low;
    n_set = 0; n_cmd = 0; n_hold = 0; bad_strobe = 0; ack_after = 0;
    @(negedge clk);
    req = 1'b1; req_sock = sk; req_space = sp; req_write = wr;
    card_wait_n = 1'b0;
    while (phase_b < 3 && guard < 3000) begin
      @(negedge clk);
      guard++;
      if (guard == 1 && !wiggle) req = 1'b0;
      if (wiggle) begin
        req_write = ~wr; req_sock = ~sk; req_space = (sp == 2'd0) ? 2'd2 : 2'd0;
      end
      low = !rd_strobe_n || !wr_strobe_n;
      if (!rd_strobe_n && !wr_strobe_n) bad_strobe = 1;
      if (wr && !rd_strobe_n) bad_strobe = 1;
      if (!wr && !wr_strobe_n) bad_strobe = 1;
      case (phase_b)
        0: if (low) begin phase_b = 1; n_cmd = 1; end else n_set++;
        1: if (low) n_cmd++; else begin phase_b = 2; n_hold = 1; end
        default: n_hold++;
      endcase
      if (low) card_wait_n = (n_cmd >= rel);
      if (ack) begin
        if (phase_b != 2) bad_strobe = 1;
        phase_b = 3;
        req = 1'b0;
      end
    end
    if (guard >= 3000) begin
      errors++;
      $display("FAIL access timeout: actual %0d clocks expected completion", guard);
    end
    @(negedge clk);
    ack_after = int'(ack);
    card_wait_n = 1'b1;
  endtask

  initial begin
    int n_set, n_cmd, n_hold, bad, ack_after, exp_cmd, stall;
    int seen_low, seen_ack;

    repeat (3) @(negedge clk);
    // R1: reset state
    check_int("R1 read strobe in reset", int'(rd_strobe_n), 1);
    check_int("R1 write strobe in reset", int'(wr_strobe_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check_int("R1 ack after reset", int'(ack), 0);

    foreach (VECS[k]) begin
      vec_t v;
      v = VECS[k];
      load_cfg(int'(v.sock) * 3 + int'(v.space), int'(v.setup), int'(v.hold), int'(v.code));
      do_access(v.sock, v.space, v.wr, int'(v.rel), 1'b0,
                n_set, n_cmd, n_hold, bad, ack_after);
      stall = (int'(v.rel) > int'(v.code) + 2) ? int'(v.rel) - (int'(v.code) + 2) : 0;
      exp_cmd = 3 * int'(v.code) + 5 + (v.wr ? 0 : 1) + stall;
      check_int($sformatf("R2 R9 setup clocks vec %0d", k), n_set, int'(v.setup) + 2);
      check_int($sformatf("%s R3 strobe clocks vec %0d", v.wr ? "R4" : "R5", k), n_cmd, exp_cmd);
      check_int($sformatf("R6 hold clocks vec %0d", k), n_hold, int'(v.hold) + 2);
      check_int($sformatf("R7 strobe choice vec %0d", k), bad, 0);
      check_int($sformatf("R6 ack single vec %0d", k), ack_after, 0);
    end

    // R8: request inputs flipped and held high across a write access
    load_cfg(2, 1, 2, 2);
    do_access(1'b0, 2'd2, 1'b1, 0, 1'b1, n_set, n_cmd, n_hold, bad, ack_after);
    check_int("R8 setup with moving selects", n_set, 3);
    check_int("R8 strobe clocks with moving selects", n_cmd, 11);
    check_int("R8 hold with moving selects", n_hold, 4);
    check_int("R8 strobe choice with moving selects", bad, 0);
    check_int("R8 ack single with moving selects", ack_after, 0);

    // R10: space code 3 is refused
    seen_low = 0; seen_ack = 0;
    @(negedge clk);
    req = 1'b1; req_sock = 1'b0; req_space = 2'd3; req_write = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!rd_strobe_n || !wr_strobe_n) seen_low = 1;
      if (ack) seen_ack = 1;
    end
    req = 1'b0; req_space = 2'd0;
    check_int("R10 no strobe for space 3", seen_low, 0);
    check_int("R10 no ack for space 3", seen_ack, 0);

    // R1: idle outputs after all accesses
    @(negedge clk);
    check_int("R1 idle strobes", int'(rd_strobe_n & wr_strobe_n), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule